// File: doc/BRIEF.md
# Sigma-Delta Loop Phase Sequencer

This block is the digital heart of a closed-loop electromechanical sigma-delta readout for a capacitive motion sensor. It cuts every sample period into four switch-control phases that never overlap. The first phase resets the sense capacitors and autozeroes the amplifier. The second integrates and quantizes the charge difference. The third pushes the force feedback onto the proof mass. The fourth is spare time for control and sensing. Each phase lasts a parameterized number of system clocks and is followed by at least one idle clock.

At the last clock of the integrate phase, the external comparator decision is captured into a flip-flop. It appears on a raw bit-stream output together with a one-cycle valid pulse. The captured bit then passes through a first-order lead compensator, 2 − z⁻¹, with bits mapped to ±1. The result is one of four signed levels. During the feedback phase, the sign of that level picks the force polarity. The magnitude is available to set the drive strength. With the default timing, a 16-clock sample period at a 1.6 MHz clock gives the 10 µs period (100 kHz sample rate) that such a loop typically runs at.

Top module: `sdm_loop_seq`

## Requirements
- R1: While reset (rst_n low) is applied, all four phase enables are low, bs_valid is low, bs_bit is 0, fb_up and fb_dn are low, and fb_level reads −1 (3'b111), which is the compensator with both history bits at 0.
- R2: Phase enables assert in the repeating order phi_en[0], phi_en[1], phi_en[2], phi_en[3], where bit k is phase k+1. phi_en[0] goes high in the cycle after the first clock edge following reset release.
- R3: Each phase enable stays high for exactly PH_CLKS consecutive clocks and is followed by GAP_CLKS idle clocks, with at least one, in which no enable is high. The sample period is therefore 4·(PH_CLKS+GAP_CLKS) clocks.
- R4: comp_in is sampled only at the clock edge that ends the last active cycle of phase 2. bs_bit changes only at that edge, and comp_in values at all other times have no effect.
- R5: bs_valid is high for exactly one cycle per sample period: the cycle right after the capture edge, which is the first idle cycle after phase 2.
- R6: fb_level (3-bit two's complement) equals 2·s(b[n]) − s(b[n−1]), with s(1)=+1 and s(0)=−1. Its value is one of {−3, −1, +1, +3}, and it takes its new value in the cycle after bs_valid.
- R7: fb_up is high exactly when phi_en[2] is high and fb_level is positive. fb_dn is high exactly when phi_en[2] is high and fb_level is negative. They are never high together.
- R8: A reset in the middle of a run clears the compensator history, so the first sample after reset uses b[n−1]=0 (−1). For example, a first bit of 1 gives +3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| comp_in | input | 1 | Comparator decision, 1 = positive |
| phi_en | output | 4 | Phase enables, bit k = phase k+1 |
| bs_bit | output | 1 | Raw captured bit stream |
| bs_valid | output | 1 | One-cycle pulse when bs_bit is new |
| fb_level | output | 3 | Compensated feedback level, signed |
| fb_up | output | 1 | Positive force select during phase 3 |
| fb_dn | output | 1 | Negative force select during phase 3 |

## Verification
The comparator is driven with several bit patterns:
- constant 0 and constant 1, which hold the compensator at ±1;
- alternating bits, which force the ±3 extremes every sample;
- a pair pattern and a pseudo-random sequence, which mix all four levels and separate the current bit from the history bit.

Outside the capture cycle, comp_in carries the inverse of the intended bit, so sampling on the wrong edge shows up as a wrong bs_bit. The phase enables are compared every cycle against a period model. A reset while the last bit is 1, followed by a run of ones, tells a cleared history (+3) apart from a stale one (+1).

// File: rtl/sdm_seq_pkg.sv
package sdm_seq_pkg;

  typedef logic signed [2:0] fb_lvl_t;

  // map a one-bit decision to +1 / -1
  function automatic fb_lvl_t bit_to_pm(input logic b);
    return b ? 3'sd1 : -3'sd1;
  endfunction

  // lead compensator 2 - z^-1 on +/-1 symbols
  function automatic fb_lvl_t lead_level(input logic cur, input logic prev);
    fb_lvl_t a;
    fb_lvl_t p;
    a = bit_to_pm(cur);
    p = bit_to_pm(prev);
    return (a + a) - p;
  endfunction

endpackage

// File: rtl/sdm_phase_timer.sv
module sdm_phase_timer #(
  parameter int PH_CLKS  = 3,
  parameter int GAP_CLKS = 1
) (
  input  logic       clk,
  input  logic       rst_n,
  output logic [3:0] phi_en,
  output logic       cap_stb
);
  localparam int GAP_EFF = (GAP_CLKS < 1) ? 1 : GAP_CLKS;
  localparam int SLOT    = PH_CLKS + GAP_EFF;
  localparam int OFF_W   = (SLOT > 1) ? $clog2(SLOT) : 1;
  localparam logic [OFF_W-1:0] OFF_LAST = OFF_W'(SLOT - 1);
  localparam logic [OFF_W-1:0] OFF_PH   = OFF_W'(PH_CLKS);
  localparam logic [OFF_W-1:0] OFF_CAP  = OFF_W'(PH_CLKS - 1);

  logic             live_q;
  logic [1:0]       slot_q;
  logic [OFF_W-1:0] off_q;
  logic             slot_end;
  logic             in_active;

  assign slot_end  = (off_q == OFF_LAST);
  assign in_active = live_q && (off_q < OFF_PH);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      live_q <= 1'b0;
      slot_q <= 2'd0;
      off_q  <= '0;
    end else begin
      live_q <= 1'b1;
      if (live_q) begin
        if (slot_end) begin
          off_q  <= '0;
          slot_q <= slot_q + 2'd1;
        end else begin
          off_q <= off_q + 1'b1;
        end
      end
    end
  end

  for (genvar k = 0; k < 4; k++) begin : g_phase
    assign phi_en[k] = in_active && (slot_q == 2'(k));
  end

  assign cap_stb = live_q && (slot_q == 2'd1) && (off_q == OFF_CAP);

  // R3: a phase that just ended is followed by an idle clock
  assert_gap_after_phase_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (|($past(phi_en) & ~phi_en)) |-> (phi_en == 4'b0000));

  // R3: at most one enable at a time
  assert_no_overlap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(phi_en));

  // R4: strobe only inside phase 2
  assert_strobe_in_phase2_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cap_stb |-> phi_en[1]);

endmodule

// File: rtl/sdm_bit_capture.sv
module sdm_bit_capture (
  input  logic clk,
  input  logic rst_n,
  input  logic cap_stb,
  input  logic comp_in,
  output logic bit_q,
  output logic valid_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_q   <= 1'b0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= cap_stb;
      if (cap_stb) bit_q <= comp_in;
    end
  end

  // R4: the bit holds between strobes
  assert_hold_between_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_stb |=> $stable(bit_q));

  // R4: a strobe takes the comparator value
  assert_take_comp_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cap_stb |=> (bit_q == $past(comp_in)));

endmodule

// File: rtl/sdm_lead_comp.sv
module sdm_lead_comp
  import sdm_seq_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    new_valid,
  input  logic    new_bit,
  output fb_lvl_t level_q
);
  logic hist_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist_q  <= 1'b0;
      level_q <= lead_level(1'b0, 1'b0);
    end else if (new_valid) begin
      level_q <= lead_level(new_bit, hist_q);
      hist_q  <= new_bit;
    end
  end

  // R6: level is always an odd value (one of -3,-1,+1,+3)
  assert_level_odd_R6: assert property (@(posedge clk) disable iff (!rst_n)
    level_q[0] == 1'b1);

  // R6: level changes only after a new bit
  assert_level_update_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !new_valid |=> $stable(level_q));

endmodule

// File: rtl/sdm_loop_seq.sv
module sdm_loop_seq
  import sdm_seq_pkg::*;
#(
  parameter int PH_CLKS  = 3,
  parameter int GAP_CLKS = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              comp_in,
  output logic [3:0]        phi_en,
  output logic              bs_bit,
  output logic              bs_valid,
  output logic signed [2:0] fb_level,
  output logic              fb_up,
  output logic              fb_dn
);
  logic    cap_stb;
  fb_lvl_t level_w;

  sdm_phase_timer #(.PH_CLKS(PH_CLKS), .GAP_CLKS(GAP_CLKS)) i_timer (
    .clk(clk), .rst_n(rst_n), .phi_en(phi_en), .cap_stb(cap_stb)
  );

  sdm_bit_capture i_cap (
    .clk(clk), .rst_n(rst_n), .cap_stb(cap_stb), .comp_in(comp_in),
    .bit_q(bs_bit), .valid_q(bs_valid)
  );

  sdm_lead_comp i_comp (
    .clk(clk), .rst_n(rst_n), .new_valid(bs_valid), .new_bit(bs_bit),
    .level_q(level_w)
  );

  assign fb_level = level_w;
  assign fb_up    = phi_en[2] && !level_w[2];
  assign fb_dn    = phi_en[2] &&  level_w[2];

  // last phase seen, kept for the ordering check
  logic [1:0] last_ph_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) last_ph_q <= 2'd3;
    else begin
      for (int j = 0; j < 4; j++) begin
        if (phi_en[j]) last_ph_q <= 2'(j);
      end
    end
  end

  for (genvar k = 0; k < 4; k++) begin : g_order
    // R2: phase k starts only after phase k-1
    assert_order_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(phi_en[k]) |-> (last_ph_q == 2'((k + 3) % 4)));
  end

  // R5: valid pulse falls in an idle cycle and lasts one cycle
  assert_valid_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    bs_valid |-> (phi_en == 4'b0000));
  assert_valid_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    bs_valid |=> !bs_valid);

  // R7: force selects only in phase 3 and never both
  assert_fb_phase3_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (fb_up || fb_dn) |-> phi_en[2]);
  assert_fb_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(fb_up && fb_dn));

endmodule

// File: tb/test_sdm_loop_seq.sv
`timescale 1ns/1ps
module test_sdm_loop_seq;
  localparam int PH   = 3;
  localparam int GAP  = 1;
  localparam int SLOT = PH + GAP;
  localparam int PER  = 4 * SLOT;
  localparam int CAP_CNT = SLOT + PH - 1;

  typedef struct { logic b; int lvl; } item_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic comp_in = 1'b0;
  logic [3:0] phi_en;
  logic bs_bit, bs_valid, fb_up, fb_dn;
  logic signed [2:0] fb_level;

  int checks = 0;
  int failures = 0;
  int k = 0;
  item_t q[$];
  int cur_m = 0;
  int pend_lvl = -1;
  int appl_lvl = -1;
  logic first_after_rst = 1'b0;
  logic pend_first = 1'b0;
  logic done = 1'b0;
  logic [7:0] lfsr = 8'hA5;

  sdm_loop_seq #(.PH_CLKS(PH), .GAP_CLKS(GAP)) i_sdm_loop_seq (
    .clk(clk), .rst_n(rst_n), .comp_in(comp_in), .phi_en(phi_en),
    .bs_bit(bs_bit), .bs_valid(bs_valid), .fb_level(fb_level),
    .fb_up(fb_up), .fb_dn(fb_dn)
  );

  always #4 clk = ~clk;

  always @(posedge clk or negedge rst_n)
    if (!rst_n) k <= 0; else k <= k + 1;

  task automatic check(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic int pm(input int b);
    return (b != 0) ? 1 : -1;
  endfunction

  function automatic logic pat_bit(input int mode, input int n);
    case (mode)
      0: return 1'b0;
      1: return 1'b1;
      2: return 1'(n % 2);
      3: return 1'((n / 2) % 2);
      default: return lfsr[0];
    endcase
  endfunction

  // driver: one sample per period, inverse value outside the capture cycle
  task automatic drive(input int mode, input int nsamp);
    int n;
    logic b;
    n = 0;
    while (n < nsamp) begin
      @(negedge clk);
      b = pat_bit(mode, n);
      if (k >= 1 && ((k - 1) % PER) == CAP_CNT) begin
        item_t it;
        comp_in = b;
        it.b = b;
        it.lvl = 2 * pm(int'(b)) - pm(cur_m);
        cur_m = int'(b);
        q.push_back(it);
        n++;
        if (mode == 4) lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      end else begin
        comp_in = ~b;
      end
    end
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (k == 0) begin
        check(phi_en == 4'b0 && !bs_valid, "R2", int'(phi_en), 0);
      end else begin
        int cnt, ph, off, expph;
        cnt = (k - 1) % PER;
        ph = cnt / SLOT;
        off = cnt % SLOT;
        expph = (off < PH) ? (1 << ph) : 0;
        check(int'(phi_en) == expph, (expph == 0) ? "R3" : "R2", int'(phi_en), expph);
        if (cnt == SLOT + PH) begin
          check(bs_valid == 1'b1, "R5", int'(bs_valid), 1);
          if (q.size() == 0) check(1'b0, "R4", 0, 1);
          else begin
            item_t it;
            it = q.pop_front();
            check(bs_bit == it.b, "R4", int'(bs_bit), int'(it.b));
            pend_lvl = it.lvl;
            pend_first = first_after_rst;
            first_after_rst = 1'b0;
          end
        end else begin
          check(bs_valid == 1'b0, "R5", int'(bs_valid), 0);
        end
        if (cnt == SLOT + PH + 1) begin
          appl_lvl = pend_lvl;
          check(int'(fb_level) == appl_lvl, pend_first ? "R8" : "R6", int'(fb_level), appl_lvl);
        end
        check(fb_up == (phi_en[2] && appl_lvl > 0) && fb_dn == (phi_en[2] && appl_lvl < 0),
              "R7", int'({fb_up, fb_dn}), int'({(expph == 4 && appl_lvl > 0), (expph == 4 && appl_lvl < 0)}));
      end
    end
  end

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    q.delete();
    cur_m = 0;
    pend_lvl = -1;
    appl_lvl = -1;
    first_after_rst = 1'b1;
    repeat (2) @(negedge clk);
    check(phi_en == 4'b0 && !bs_valid && !fb_up && !fb_dn, "R1", int'(phi_en), 0);
    check(bs_bit == 1'b0, "R1", int'(bs_bit), 0);
    check(int'(fb_level) == -1, "R1", int'(fb_level), -1);
    rst_n = 1'b1;
  endtask

  initial begin
    do_reset();
    drive(0, 6);
    drive(1, 6);
    drive(2, 8);
    drive(3, 8);
    drive(4, 24);
    drive(1, 3);
    repeat (PER) @(negedge clk);
    do_reset();
    drive(1, 4);
    drive(4, 10);
    repeat (PER) @(negedge clk);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(200000 * 8);
    if (!done) begin
      done = 1'b1;
      failures++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule